// File: doc/BRIEF.md
# TDM Slot Serial Port (Slave Side)

This block is the receiving end of a time-division-multiplexed audio link where a converter or codec is the timing master. The master supplies a bit clock and a frame sync. Each frame carries a fixed number of equal-width slots, eight slots of 32 bits by default, so one frame lasts 256 bit clocks. At 48 kHz frames on a 12.288 MHz bit clock, frames arrive about 20.8 µs apart. Within each frame the port captures incoming slots into a receive buffer and shifts outgoing slots from a transmit buffer.

The bit clock and frame sync are oversampled by the chip's own clock through a synchronizer. The first data bit of slot 0 follows the bit clock on which the frame sync is sampled high. Separate per-slot masks pick which slots are captured and which are driven. A typical codec layout puts three left outputs in slots 0–2 and three right outputs in slots 4–6, with slots 3 and 7 unused (transmit mask 0x77). The left and right inputs sit in slots 0 and 4 (receive mask 0x11). On disabled transmit slots the output enable is dropped, so the pad buffer releases the line to high impedance.

A one-cycle done strobe tells the host side that a complete frame has been exchanged. If a frame sync arrives before a frame is complete, the port realigns to slot 0 and raises a framing-error flag.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, `sd_oe`, `frame_done` and `frame_err` are 0 and every bit of `rx_frame` is 0.
- R2: A frame begins on the rising bit-clock edge where `fsync` is sampled high. The next 256 rising edges carry frame bits 0..255. Bit k belongs to slot k/32, and each slot arrives most significant bit first.
- R3: When slot i completes, its word is written to `rx_frame[i*32 +: 32]` only if bit i of the receive mask latched at frame start is 1. Otherwise the previous word is kept.
- R4: Frame bit k is driven on `sd_out` after the falling bit-clock edge that precedes its rising edge. The bit is taken from `tx_frame[i*32 +: 32]` for slot i, most significant bit first.
- R5: `sd_oe` is 1 through slot i only if bit i of the latched transmit mask is 1. `sd_oe` is 0 when no frame is in progress.
- R6: `tx_frame`, `tx_mask` and `rx_mask` are latched at frame start. Changes made to them during a frame take effect only at the next frame start.
- R7: `frame_done` is a single-cycle pulse raised once after bit 255 (the last bit of slot 7) is captured.
- R8: A frame sync sampled before bit 255 restarts the frame at slot 0 and sets `frame_err` to 1. The truncated frame raises no `frame_done`, and slots it completed are still stored. A frame start that follows exactly 256 bits, or that follows an idle line, sets `frame_err` to 0.
- R9: If no frame sync accompanies bit 255, the port goes idle (`sd_oe` 0, nothing captured) until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the link master |
| fsync | input | 1 | Frame sync from the link master, sampled on rising bit clock |
| sd_in | input | 1 | Serial receive data, sampled on rising bit clock |
| tx_frame | input | SLOTS*SLOT_W | Transmit words, slot i in bits i*SLOT_W upward |
| tx_mask | input | SLOTS | Per-slot transmit enables |
| rx_mask | input | SLOTS | Per-slot receive enables |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Output enable for the serial data pad buffer |
| rx_frame | output | SLOTS*SLOT_W | Received words, slot i in bits i*SLOT_W upward |
| frame_done | output | 1 | One-cycle pulse at the end of a complete frame |
| frame_err | output | 1 | Set when the latest frame start came early |

## Verification
The assertions check several rules on every cycle. The transmit data and its enable may change only right after a detected falling bit-clock edge. The receive buffer may change only after a rising edge. The error flag may move only at a frame start. The done strobe never lasts more than one cycle and always follows a rising edge, and the enable is dropped whenever a falling edge finds no frame in progress. Only the bench scenarios can show that the right bits land in the right slots. The same holds for the mask choices, a change made mid-frame waiting for the next frame, a truncated frame realigning and keeping its finished slots, and the port going quiet when a frame sync is missing.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

   // One oversampled view of the serial link per system clock
   typedef struct packed {
      logic rise;   // bit clock rose this cycle
      logic fall;   // bit clock fell this cycle
      logic fs;     // frame sync level as seen with this edge
      logic din;    // serial data level as seen with this edge
   } tdm_evt_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
   import tdm_slot_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bclk,
   input  logic     fsync,
   input  logic     sd_in,
   output tdm_evt_t evt
);

   localparam int LANES = 3;

   logic [STAGES-1:0][LANES-1:0] chain;
   logic                         bclk_d;
   logic [LANES-1:0]             synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         bclk_d <= 1'b0;
      end else begin
         chain[0] <= {bclk, fsync, sd_in};
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
         bclk_d <= chain[STAGES-1][2];
      end
   end

   assign synced   = chain[STAGES-1];
   assign evt.rise = synced[2] & ~bclk_d;
   assign evt.fall = ~synced[2] & bclk_d;
   assign evt.fs   = synced[1];
   assign evt.din  = synced[0];

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
   import tdm_slot_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 32,
   localparam int FRAME_BITS = SLOTS * SLOT_W,
   localparam int POS_W      = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tdm_evt_t         evt,
   output logic             active,
   output logic [POS_W-1:0] pos,
   output logic             frame_start,
   output logic             take,
   output logic             frame_end,
   output logic             frame_err
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         pos       <= '0;
         frame_err <= 1'b0;
      end else if (evt.rise) begin
         if (evt.fs) begin
            // realign; early when a frame was running and not at its last bit
            active    <= 1'b1;
            pos       <= '0;
            frame_err <= active && (pos != LAST);
         end else if (active) begin
            if (pos == LAST) begin
               active <= 1'b0;
            end else begin
               pos <= pos + 1'b1;
            end
         end
      end
   end

   assign frame_start = evt.rise & evt.fs;
   assign take        = evt.rise & active;
   assign frame_end   = take & (pos == LAST);

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 32,
   localparam int FRAME_BITS = SLOTS * SLOT_W,
   localparam int POS_W      = $clog2(FRAME_BITS),
   localparam int BIT_W      = $clog2(SLOT_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic                  frame_start,
   input  logic                  din,
   input  logic [POS_W-1:0]      pos,
   input  logic [SLOTS-1:0]      rx_mask,
   output logic [FRAME_BITS-1:0] rx_frame
);

   localparam int SLOT_IW = POS_W - BIT_W;

   logic [SLOTS-1:0]    mask_lat;
   logic [SLOT_W-2:0]   shreg;
   logic [SLOT_W-1:0]   word_now;
   logic [SLOT_IW-1:0]  slot_idx;
   logic                slot_last;

   assign slot_idx  = pos[POS_W-1:BIT_W];
   assign slot_last = (pos[BIT_W-1:0] == BIT_W'(SLOT_W - 1));
   assign word_now  = {shreg, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_lat <= '0;
         shreg    <= '0;
      end else begin
         if (frame_start) mask_lat <= rx_mask;
         if (take)        shreg    <= word_now[SLOT_W-2:0];
      end
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [SLOT_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (take && slot_last && (slot_idx == SLOT_IW'(i)) && mask_lat[i]) begin
            word_q <= word_now;
         end
      end
      assign rx_frame[i*SLOT_W +: SLOT_W] = word_q;
   end

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 32,
   localparam int FRAME_BITS = SLOTS * SLOT_W,
   localparam int POS_W      = $clog2(FRAME_BITS),
   localparam int BIT_W      = $clog2(SLOT_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  fall,
   input  logic                  active,
   input  logic [POS_W-1:0]      pos,
   input  logic [FRAME_BITS-1:0] tx_frame,
   input  logic [SLOTS-1:0]      tx_mask,
   output logic                  sd_out,
   output logic                  sd_oe
);

   localparam int SLOT_IW = POS_W - BIT_W;

   logic [FRAME_BITS-1:0] tx_lat;
   logic [SLOTS-1:0]      mask_lat;
   logic [SLOT_IW-1:0]    slot_idx;
   logic [POS_W-1:0]      bit_sel;

   assign slot_idx = pos[POS_W-1:BIT_W];
   // MSB first: bit b of a slot maps to word bit SLOT_W-1-b
   assign bit_sel  = {slot_idx, ~pos[BIT_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_lat   <= '0;
         mask_lat <= '0;
         sd_out   <= 1'b0;
         sd_oe    <= 1'b0;
      end else begin
         if (frame_start) begin
            tx_lat   <= tx_frame;
            mask_lat <= tx_mask;
         end
         if (fall) begin
            if (active && mask_lat[slot_idx]) begin
               sd_oe  <= 1'b1;
               sd_out <= tx_lat[bit_sel];
            end else begin
               sd_oe  <= 1'b0;
               sd_out <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
   import tdm_slot_pkg::*;
#(
   parameter int SLOTS       = 8,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_BITS = SLOTS * SLOT_W,
   localparam int POS_W      = $clog2(FRAME_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bclk,
   input  logic                  fsync,
   input  logic                  sd_in,
   input  logic [FRAME_BITS-1:0] tx_frame,
   input  logic [SLOTS-1:0]      tx_mask,
   input  logic [SLOTS-1:0]      rx_mask,
   output logic                  sd_out,
   output logic                  sd_oe,
   output logic [FRAME_BITS-1:0] rx_frame,
   output logic                  frame_done,
   output logic                  frame_err
);

   if (!is_pow2(SLOTS) || SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (!is_pow2(SLOT_W) || SLOT_W < 2) begin : g_bad_width
      $error("SLOT_W must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   tdm_evt_t         evt;
   logic             active_q;
   logic [POS_W-1:0] pos_q;
   logic             frame_start_w;
   logic             take_w;
   logic             frame_end_w;

   tdm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .bclk  (bclk),
      .fsync (fsync),
      .sd_in (sd_in),
      .evt   (evt)
   );

   tdm_frame_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) ctr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .active      (active_q),
      .pos         (pos_q),
      .frame_start (frame_start_w),
      .take        (take_w),
      .frame_end   (frame_end_w),
      .frame_err   (frame_err)
   );

   tdm_rx_path #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) rx_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take_w),
      .frame_start (frame_start_w),
      .din         (evt.din),
      .pos         (pos_q),
      .rx_mask     (rx_mask),
      .rx_frame    (rx_frame)
   );

   tdm_tx_path #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) tx_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start_w),
      .fall        (evt.fall),
      .active      (active_q),
      .pos         (pos_q),
      .tx_frame    (tx_frame),
      .tx_mask     (tx_mask),
      .sd_out      (sd_out),
      .sd_oe       (sd_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_done <= 1'b0;
      else        frame_done <= frame_end_w;
   end

endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
   parameter int FRAME_BITS = 256
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rise,
   input logic                  fall,
   input logic                  frame_start,
   input logic                  active,
   input logic                  sd_out,
   input logic                  sd_oe,
   input logic [FRAME_BITS-1:0] rx_frame,
   input logic                  frame_done,
   input logic                  frame_err
);

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r7_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(rise));

   a_r4_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_out != $past(sd_out)) |-> $past(fall));

   a_r5_enable_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_oe != $past(sd_oe)) |-> $past(fall));

   a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !active) |=> !sd_oe);

   a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame != $past(rx_frame)) |-> $past(rise));

   a_r8_err_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err != $past(frame_err)) |-> $past(frame_start));

endmodule

bind tdm_slot_port tdm_slot_port_chk #(.FRAME_BITS(FRAME_BITS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rise        (evt.rise),
   .fall        (evt.fall),
   .frame_start (frame_start_w),
   .active      (active_q),
   .sd_out      (sd_out),
   .sd_oe       (sd_oe),
   .rx_frame    (rx_frame),
   .frame_done  (frame_done),
   .frame_err   (frame_err)
);

// File: tb/tdm_slot_port_tb_top.sv
module tdm_slot_port_tb_top;

   localparam int SLOTS = 8;
   localparam int W     = 32;
   localparam int FB    = SLOTS * W;
   localparam int HALF  = 8;

   logic          clk = 1'b0;
   logic          rst_n, bclk, fsync, sd_in;
   logic [FB-1:0] tx_frame, rx_frame;
   logic [7:0]    tx_mask, rx_mask;
   logic          sd_out, sd_oe, frame_done, frame_err;

   always #2 clk = ~clk;

   tdm_slot_port dut_i (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sd_in(sd_in),
      .tx_frame(tx_frame), .tx_mask(tx_mask), .rx_mask(rx_mask),
      .sd_out(sd_out), .sd_oe(sd_oe), .rx_frame(rx_frame),
      .frame_done(frame_done), .frame_err(frame_err)
   );

   int vectors = 0, miscompares = 0;
   bit finished = 1'b0;
   logic [FB-1:0] exp_q[$];
   logic [FB-1:0] rx_model = '0;
   logic [FB-1:0] lat_tx;
   logic [7:0]    lat_txm, lat_rxm;
   logic          prev_done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   function automatic logic [FB-1:0] pat(input int seed);
      logic [FB-1:0] v;
      for (int i = 0; i < SLOTS; i++) begin
         v[i*W +: W] = {8'(seed), 8'(i + 16), 8'(8'hC3 ^ 8'(seed * 7 + i)), 8'(i * 29 + seed)};
      end
      return v;
   endfunction

   // One bit period: master moves fsync/data on the falling edge, samples before the rise
   task automatic bit_cycle(input logic fs, input logic din, output logic got_d, output logic got_oe);
      @(negedge clk);
      bclk = 1'b0; fsync = fs; sd_in = din;
      repeat (HALF - 1) @(negedge clk);
      got_d = sd_out; got_oe = sd_oe;
      @(negedge clk);
      bclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (fs) begin
         lat_tx = tx_frame; lat_txm = tx_mask; lat_rxm = rx_mask;
      end
   endtask

   task automatic send_frame(input logic [FB-1:0] words, input int nbits, input logic fs_end,
                             input int chg_at, input logic [FB-1:0] new_tx,
                             input logic [7:0] new_txm, input logic [7:0] new_rxm);
      logic [FB-1:0] cur_tx;
      logic [7:0]    cur_txm, cur_rxm;
      logic [W-1:0]  got_w;
      logic          d, oe, oe_all, oe_any;
      cur_tx = lat_tx; cur_txm = lat_txm; cur_rxm = lat_rxm;
      got_w = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int k = 0; k < nbits; k++) begin
         int s, b;
         s = k / W; b = k % W;
         if (k == chg_at) begin
            tx_frame = new_tx; tx_mask = new_txm; rx_mask = new_rxm;
         end
         if (b == W - 1) begin
            if (cur_rxm[s]) rx_model[s*W +: W] = words[s*W +: W];
            if (k == FB - 1) exp_q.push_back(rx_model);
         end
         bit_cycle((k == nbits - 1) && fs_end, words[s*W + (W - 1 - b)], d, oe);
         got_w[W - 1 - b] = d;
         if (b == 0) begin oe_all = oe; oe_any = oe; end
         else begin oe_all = oe_all & oe; oe_any = oe_any | oe; end
         if (b == W - 1) begin
            // R5: enable follows latched mask for the whole slot; R4/R6: word from latched buffer
            check((oe_all == cur_txm[s]) && (oe_any == cur_txm[s]), "R5 slot enable",
                  FB'({oe_any, oe_all}), FB'({cur_txm[s], cur_txm[s]}));
            if (cur_txm[s])
               check(got_w == cur_tx[s*W +: W], "R4 R6 transmit word", FB'(got_w), FB'(cur_tx[s*W +: W]));
         end
      end
   endtask

   // Scoreboard monitor: each done strobe consumes one expected receive buffer image
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (frame_done && prev_done) check(1'b0, "R7 done wider than one cycle", FB'(1), FB'(0));
         if (frame_done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 R8 unexpected done", FB'(1), FB'(0));
            end else begin
               logic [FB-1:0] e;
               e = exp_q.pop_front();
               check(rx_frame == e, "R2 R3 receive buffer", rx_frame, e);
            end
         end
      end
      prev_done = frame_done;
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", FB'(0), FB'(1));
      finish_run();
   end

   initial begin
      logic d, oe, idle_oe;
      rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sd_in = 1'b0;
      tx_frame = pat(1); tx_mask = 8'hFF; rx_mask = 8'hFF;
      lat_tx = '0; lat_txm = '0; lat_rxm = '0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      check(sd_oe == 1'b0, "R1 enable after reset", FB'(sd_oe), FB'(0));
      check(frame_done == 1'b0, "R1 done after reset", FB'(frame_done), FB'(0));
      check(frame_err == 1'b0, "R1 error after reset", FB'(frame_err), FB'(0));
      check(rx_frame == '0, "R1 receive buffer after reset", rx_frame, '0);

      // first frame start on an idle line
      bit_cycle(1'b1, 1'b0, d, oe);
      check(oe == 1'b0, "R5 enable before any frame", FB'(oe), FB'(0));
      // R6: port values change right after the start, frame 1 keeps the latched ones
      tx_frame = pat(2); tx_mask = 8'h77; rx_mask = 8'h11;
      send_frame(pat(11), FB, 1'b1, -1, '0, 8'h00, 8'h00);
      check(frame_err == 1'b0, "R8 on-time start clears error", FB'(frame_err), FB'(0));

      // codec layout masks, with a mid-frame change (R6)
      send_frame(pat(12), FB, 1'b1, 40, pat(3), 8'hF0, 8'h0F);
      send_frame(pat(13), FB, 1'b1, -1, '0, 8'h00, 8'h00);

      // R8 early frame sync after 100 bits
      send_frame(pat(14), 100, 1'b1, -1, '0, 8'h00, 8'h00);
      check(frame_err == 1'b1, "R8 early sync sets error", FB'(frame_err), FB'(1));
      send_frame(pat(15), FB, 1'b1, -1, '0, 8'h00, 8'h00);
      check(frame_err == 1'b0, "R8 full frame clears error", FB'(frame_err), FB'(0));

      // R9 missing frame sync: port goes quiet
      tx_mask = 8'hFF; rx_mask = 8'hFF;
      send_frame(pat(16), FB, 1'b0, -1, '0, 8'h00, 8'h00);
      idle_oe = 1'b0;
      for (int k = 0; k < 20; k++) begin
         bit_cycle(1'b0, 1'b1, d, oe);
         idle_oe = idle_oe | oe;
      end
      check(idle_oe == 1'b0, "R9 enable low while idle", FB'(idle_oe), FB'(0));
      check(exp_q.size() == 0, "R9 R7 no pending frames while idle", FB'(exp_q.size()), FB'(0));
      check(frame_err == 1'b0, "R9 idle is not an error", FB'(frame_err), FB'(0));

      bit_cycle(1'b1, 1'b0, d, oe);
      check(frame_err == 1'b0, "R8 start after idle is not early", FB'(frame_err), FB'(0));
      send_frame(pat(17), FB, 1'b1, -1, '0, 8'h00, 8'h00);
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R7 every full frame signalled", FB'(exp_q.size()), FB'(0));
      finish_run();
   end

endmodule